// File: doc/BRIEF.md
# Raster Operation Mix Unit

This block forms the byte written back to frame memory when a drawing engine paints one pixel. It combines a source operand S with the destination pixel D, which is the byte already in display memory at that spot, using one of sixteen bitwise logic functions. Two 16-bit mix registers hold the settings. One is used for foreground pixels and one for background pixels. Each register picks the function and also picks where S comes from: the background colour, the foreground colour, pixel-transfer data or bitmap data taken from display memory.

The drawing engine presents D, the candidate source bytes and a strobe, and says whether the pixel is foreground or background. One cycle later the block returns the result byte with a valid flag and a write-enable. The function that leaves the destination unchanged holds the write-enable low, so memory is not touched. Software reaches the two mix registers through a single write port. A read port returns the register chosen by the select input.

Top module: `rop_mix_unit`

## Requirements
- R1: After reset both mix registers read 0, and `res_vld` and `res_we` are 0.
- R2: A cycle with `reg_we` high loads all 16 bits of `reg_wdata` into the register named by `reg_sel` (1 = foreground, 0 = background), and the other register keeps its value. `reg_rdata` shows the register named by `reg_sel` without any clock delay.
- R3: Bits 3:0 of the active mix register choose the function, and every function acts bitwise on all 8 bits: 0 ~D, 1 all zeros, 2 all ones, 3 D, 4 ~S, 5 S^D, 6 ~(S^D), 7 S, 8 ~(S&D), 9 ~S|D, 10 S|~D, 11 S|D, 12 S&D, 13 S&~D, 14 ~S&D, 15 ~(S|D).
- R4: Bits 6:5 of the active mix register choose S: 0 is `bg_col`, 1 is `fg_col`, 2 is `xfer_pix`, 3 is `bmp_pix`.
- R5: When `px_is_fg` is 1 the foreground register is active. When it is 0 the background register is active.
- R6: `res_pix`, `res_we` and `res_vld` are registered. `res_vld` is high in the cycle that follows each cycle in which `px_go` is high.
- R7: With function 3, `res_we` stays 0 while `res_vld` is 1, and `res_pix` equals D. Every other function raises `res_we` together with `res_vld`.
- R8: In the cycle after a cycle with `px_go` low, `res_vld` and `res_we` are 0 and `res_pix` keeps its previous value.
- R9: If a register write and `px_go` arrive in the same cycle, the pixel uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for a mix register |
| reg_sel | input | 1 | Register select: 1 foreground, 0 background |
| reg_wdata | input | 16 | Mix register write data |
| reg_rdata | output | 16 | Contents of the selected mix register |
| px_go | input | 1 | Pixel strobe |
| px_is_fg | input | 1 | Pixel is foreground (1) or background (0) |
| dst_pix | input | 8 | Destination byte D |
| fg_col | input | 8 | Foreground colour |
| bg_col | input | 8 | Background colour |
| xfer_pix | input | 8 | Pixel-transfer data byte |
| bmp_pix | input | 8 | Bitmap source byte from display memory |
| res_pix | output | 8 | Result byte |
| res_we | output | 1 | Write-enable for the result |
| res_vld | output | 1 | Result valid |

## Verification
The assertions check the timing rules on every cycle. They cover the valid flag following the strobe, the result holding when idle, the write-enable being suppressed together with D passing through for function 3, the constant-zero function, and register writes that load one register while leaving the other alone. What only the bench scenarios show is the exact value of each of the sixteen functions under each of the four source choices, for both the foreground and the background register. It sweeps every combination over two data patterns and also checks that a write in the same cycle as a pixel does not affect that pixel.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int MIX_FN_LSB  = 0;
    localparam int MIX_FN_W    = 4;
    localparam int MIX_SRC_LSB = 5;
    localparam int MIX_SRC_W   = 2;

    typedef enum logic [MIX_SRC_W-1:0] {
        SRC_BGCOL = 2'd0,
        SRC_FGCOL = 2'd1,
        SRC_XFER  = 2'd2,
        SRC_BMP   = 2'd3
    } src_e;

    typedef enum logic [MIX_FN_W-1:0] {
        FN_NOT_D    = 4'd0,
        FN_ZERO     = 4'd1,
        FN_ONE      = 4'd2,
        FN_KEEP     = 4'd3,
        FN_NOT_S    = 4'd4,
        FN_XOR      = 4'd5,
        FN_XNOR     = 4'd6,
        FN_S        = 4'd7,
        FN_NAND     = 4'd8,
        FN_NS_OR_D  = 4'd9,
        FN_S_OR_ND  = 4'd10,
        FN_OR       = 4'd11,
        FN_AND      = 4'd12,
        FN_S_AND_ND = 4'd13,
        FN_NS_AND_D = 4'd14,
        FN_NOR      = 4'd15
    } fn_e;

endpackage

// File: rtl/rop_mix_regs.sv
module rop_mix_regs #(
    parameter int NREG  = 2,
    parameter int MIX_W = 16,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [MIX_W-1:0]           wr_data,
    output logic [NREG-1:0][MIX_W-1:0] mix_o
);

    logic [MIX_W-1:0] regs_d [NREG];
    logic [MIX_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign mix_o[g] = regs_q[g];
    end

endmodule

// File: rtl/rop_src_sel.sv
module rop_src_sel
    import rop_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  src_e             sel,
    input  logic [PIX_W-1:0] bg_col,
    input  logic [PIX_W-1:0] fg_col,
    input  logic [PIX_W-1:0] xfer_pix,
    input  logic [PIX_W-1:0] bmp_pix,
    output logic [PIX_W-1:0] src
);

    always_comb begin
        unique case (sel)
            SRC_BGCOL: src = bg_col;
            SRC_FGCOL: src = fg_col;
            SRC_XFER:  src = xfer_pix;
            default:   src = bmp_pix;
        endcase
    end

endmodule

// File: rtl/rop_logic_fn.sv
module rop_logic_fn
    import rop_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  fn_e              fn,
    input  logic [PIX_W-1:0] s,
    input  logic [PIX_W-1:0] d,
    output logic [PIX_W-1:0] res,
    output logic             keep
);

    always_comb begin
        keep = 1'b0;
        unique case (fn)
            FN_NOT_D:    res = ~d;
            FN_ZERO:     res = '0;
            FN_ONE:      res = '1;
            FN_KEEP: begin
                res  = d;
                keep = 1'b1;
            end
            FN_NOT_S:    res = ~s;
            FN_XOR:      res = s ^ d;
            FN_XNOR:     res = ~(s ^ d);
            FN_S:        res = s;
            FN_NAND:     res = ~(s & d);
            FN_NS_OR_D:  res = ~s | d;
            FN_S_OR_ND:  res = s | ~d;
            FN_OR:       res = s | d;
            FN_AND:      res = s & d;
            FN_S_AND_ND: res = s & ~d;
            FN_NS_AND_D: res = ~s & d;
            default:     res = ~(s | d);
        endcase
    end

endmodule

// File: rtl/rop_mix_unit.sv
module rop_mix_unit
    import rop_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [MIX_W-1:0] reg_wdata,
    output logic [MIX_W-1:0] reg_rdata,
    input  logic             px_go,
    input  logic             px_is_fg,
    input  logic [PIX_W-1:0] dst_pix,
    input  logic [PIX_W-1:0] fg_col,
    input  logic [PIX_W-1:0] bg_col,
    input  logic [PIX_W-1:0] xfer_pix,
    input  logic [PIX_W-1:0] bmp_pix,
    output logic [PIX_W-1:0] res_pix,
    output logic             res_we,
    output logic             res_vld
);

    localparam int NREG   = 2;
    localparam int IDX_BG = 0;
    localparam int IDX_FG = 1;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             we;
        logic             vld;
    } out_t;

    logic [NREG-1:0][MIX_W-1:0] mix_all;
    logic [MIX_W-1:0]           fg_mix_w;
    logic [MIX_W-1:0]           bg_mix_w;
    logic [MIX_W-1:0]           act_mix;
    src_e                       act_src;
    fn_e                        act_fn;
    logic [PIX_W-1:0]           src_byte;
    logic [PIX_W-1:0]           fn_res;
    logic                       fn_keep;
    out_t                       out_d;
    out_t                       out_q;

    rop_mix_regs #(
        .NREG  (NREG),
        .MIX_W (MIX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .mix_o   (mix_all)
    );

    assign fg_mix_w  = mix_all[IDX_FG];
    assign bg_mix_w  = mix_all[IDX_BG];
    assign reg_rdata = reg_sel ? fg_mix_w : bg_mix_w;

    always_comb begin
        act_mix = px_is_fg ? fg_mix_w : bg_mix_w;
        act_src = src_e'(act_mix[MIX_SRC_LSB +: MIX_SRC_W]);
        act_fn  = fn_e'(act_mix[MIX_FN_LSB +: MIX_FN_W]);
    end

    rop_src_sel #(
        .PIX_W (PIX_W)
    ) u_src (
        .sel      (act_src),
        .bg_col   (bg_col),
        .fg_col   (fg_col),
        .xfer_pix (xfer_pix),
        .bmp_pix  (bmp_pix),
        .src      (src_byte)
    );

    rop_logic_fn #(
        .PIX_W (PIX_W)
    ) u_fn (
        .fn   (act_fn),
        .s    (src_byte),
        .d    (dst_pix),
        .res  (fn_res),
        .keep (fn_keep)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = px_go;
        out_d.we  = px_go && !fn_keep;
        if (px_go) begin
            out_d.pix = fn_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_pix = out_q.pix;
    assign res_we  = out_q.we;
    assign res_vld = out_q.vld;

endmodule

// File: rtl/rop_mix_chk.sv
module rop_mix_chk #(
    parameter int PIX_W = 8,
    parameter int MIX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [MIX_W-1:0] reg_wdata,
    input logic             px_go,
    input logic             px_is_fg,
    input logic [PIX_W-1:0] dst_pix,
    input logic [PIX_W-1:0] res_pix,
    input logic             res_we,
    input logic             res_vld,
    input logic [MIX_W-1:0] fg_mix,
    input logic [MIX_W-1:0] bg_mix
);

    logic [3:0] sel_fn;
    assign sel_fn = px_is_fg ? fg_mix[3:0] : bg_mix[3:0];

    a_r6_vld_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        px_go |=> res_vld);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !px_go |=> (!res_vld && !res_we));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !px_go |=> $stable(res_pix));

    a_r7_keep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (px_go && sel_fn == 4'd3) |=> (!res_we && res_pix == $past(dst_pix)));

    a_r7_write_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (px_go && sel_fn != 4'd3) |=> res_we);

    a_r3_zero_fn: assert property (@(posedge clk) disable iff (!rst_n)
        (px_go && sel_fn == 4'd1) |=> (res_pix == '0));

    a_r2_fg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> (fg_mix == $past(reg_wdata) && $stable(bg_mix)));

    a_r2_bg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel) |=> (bg_mix == $past(reg_wdata) && $stable(fg_mix)));

    a_r2_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(fg_mix) && $stable(bg_mix)));

endmodule

bind rop_mix_unit rop_mix_chk #(
    .PIX_W (PIX_W),
    .MIX_W (MIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .px_go     (px_go),
    .px_is_fg  (px_is_fg),
    .dst_pix   (dst_pix),
    .res_pix   (res_pix),
    .res_we    (res_we),
    .res_vld   (res_vld),
    .fg_mix    (fg_mix_w),
    .bg_mix    (bg_mix_w)
);

// File: tb/sim_rop_mix_unit.sv
`timescale 1ns/1ps
module sim_rop_mix_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        px_go = 1'b0;
    logic        px_is_fg = 1'b0;
    logic [7:0]  dst_pix = '0;
    logic [7:0]  fg_col = '0;
    logic [7:0]  bg_col = '0;
    logic [7:0]  xfer_pix = '0;
    logic [7:0]  bmp_pix = '0;
    logic [7:0]  res_pix;
    logic        res_we;
    logic        res_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rop_mix_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .px_go(px_go),
        .px_is_fg(px_is_fg), .dst_pix(dst_pix), .fg_col(fg_col),
        .bg_col(bg_col), .xfer_pix(xfer_pix), .bmp_pix(bmp_pix),
        .res_pix(res_pix), .res_we(res_we), .res_vld(res_vld)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input int fn, input logic [7:0] s, input logic [7:0] d);
        logic [7:0] r;
        case (fn)
            0:  r = 8'hFF - d;
            1:  r = 8'h00;
            2:  r = 8'hFF;
            3:  r = d;
            4:  r = 8'hFF - s;
            5:  r = (s | d) & ~(s & d);
            6:  r = ~((s | d) & ~(s & d));
            7:  r = s;
            8:  r = ~s | ~d;
            9:  r = (8'hFF - s) | d;
            10: r = s | (8'hFF - d);
            11: r = s | d;
            12: r = ~(~s | ~d);
            13: r = s & (8'hFF - d);
            14: r = (8'hFF - s) & d;
            default: r = ~s & ~d;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] pick(input int src);
        case (src)
            0: return bg_col;
            1: return fg_col;
            2: return xfer_pix;
            default: return bmp_pix;
        endcase
    endfunction

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = val;
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=finish", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] last;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        reg_sel = 1'b1; #1;
        chk("R1 fg reg", reg_rdata, 16'h0);
        reg_sel = 1'b0; #1;
        chk("R1 bg reg", reg_rdata, 16'h0);
        chk("R1 vld", res_vld, 1'b0);
        chk("R1 we", res_we, 1'b0);

        // R2: full-width write, other register untouched
        wr_reg(1'b1, 16'hBEEF);
        reg_sel = 1'b1; #1;
        chk("R2 fg readback", reg_rdata, 16'hBEEF);
        reg_sel = 1'b0; #1;
        chk("R2 bg untouched", reg_rdata, 16'h0);
        wr_reg(1'b0, 16'h1234);
        reg_sel = 1'b0; #1;
        chk("R2 bg readback", reg_rdata, 16'h1234);
        reg_sel = 1'b1; #1;
        chk("R2 fg untouched", reg_rdata, 16'hBEEF);

        // R3 R4 R5 R6 R7 R8: sweep of functions, sources, fg/bg, two patterns
        for (int p = 0; p < 2; p++) begin
            dst_pix  = p ? 8'hF0 : 8'h3C;
            fg_col   = p ? 8'h0F : 8'hA5;
            bg_col   = p ? 8'h81 : 8'h5A;
            xfer_pix = p ? 8'h66 : 8'hC3;
            bmp_pix  = p ? 8'h99 : 8'h96;
            for (int w = 0; w < 2; w++) begin
                for (int fn = 0; fn < 16; fn++) begin
                    for (int src = 0; src < 4; src++) begin
                        logic [15:0] mix;
                        logic [15:0] other;
                        logic [7:0]  exp;
                        mix   = {9'h1A5, src[1:0], 1'b0, fn[3:0]};
                        other = (fn == 2) ? 16'h0001 : 16'h0002;
                        wr_reg(w[0], mix);
                        wr_reg(~w[0], other);
                        chk("R8 idle vld", res_vld, 1'b0);
                        last = res_pix;
                        tick();
                        chk("R8 hold pix", res_pix, last);
                        exp = model(fn, pick(src), dst_pix);
                        px_go    = 1'b1;
                        px_is_fg = w[0];
                        tick();
                        px_go = 1'b0;
                        chk("R6 vld", res_vld, 1'b1);
                        chk((w == 1) ? "R3/R4 R5 fg pix" : "R3/R4 R5 bg pix", res_pix, exp);
                        chk("R7 we", res_we, (fn == 3) ? 1'b0 : 1'b1);
                    end
                end
            end
        end

        // R9: write and pixel in the same cycle
        dst_pix = 8'h3C;
        fg_col  = 8'hA5;
        wr_reg(1'b1, 16'h0000);
        reg_we    = 1'b1;
        reg_sel   = 1'b1;
        reg_wdata = 16'h0027;
        px_go     = 1'b1;
        px_is_fg  = 1'b1;
        tick();
        reg_we = 1'b0;
        px_go  = 1'b0;
        chk("R9 old mix used", res_pix, 8'hC3);
        reg_sel = 1'b1; #1;
        chk("R9 new mix stored", reg_rdata, 16'h0027);
        px_go = 1'b1;
        tick();
        px_go = 1'b0;
        chk("R9 new mix next", res_pix, 8'hA5);
        tick();
        chk("R8 vld drop", res_vld, 1'b0);
        chk("R8 we drop", res_we, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule